// File: doc/BRIEF.md
# ADC Power-Down and Wake-Up Sequencer

This controller sits on the host side of a sampling converter that has two low-power states. In the light state, everything except the voltage reference is switched off. In the deep state, the reference is switched off as well. The controller drives the two power-down lines and the active-low convert-start strobe, and it watches the converter's active-low busy line. Its main job is to make sure that no convert-start ever reaches the converter before the converter has recovered from the power-down state it just left. A conversion started too early returns wrong data.

The recovery time depends on two things. One is which state is being left. The other is whether the reference is internal, and so was switched off in the deep state, or external and kept powered. All times are given in nanoseconds and turned into clock cycles with ceiling rounding, based on a clock-frequency parameter.

An optional automatic mode puts the converter into the light state as soon as each conversion finishes. A request made while the converter is recovering is held and issued on the first cycle in which it is legal. A request that cannot be accepted is reported on a one-cycle error pulse.

Top module: `adc_wake_seq`

## Requirements
- R1: During reset, `nap_o` and `stby_o` are low, `convst_n_o` is high and `ready_o` and `err_o` are low. After reset is released, the block treats the converter as leaving the deep state with the internal reference. `ready_o` first reads high after exactly `INT_CYC` clock edges.
- R2: Every recovery time in cycles is ceil(ns × CLK_MHZ / 1000), with a minimum of 1. This applies to the light-state time, the deep-state internal-reference time and the deep-state external-reference time. The external-reference time defaults to the light-state time.
- R3: While `ready_o` is high, a one-cycle `conv_req` drives `convst_n_o` low from the next cycle for exactly `CNV_LOW_CYC` cycles. `ready_o` stays low from then until the conversion ends, which is when `cnv_busy_n` has been seen low and then high again.
- R4: When a conversion ends and `auto_nap_en` is 1, `nap_o` rises on the next cycle. When `auto_nap_en` is 0, `ready_o` rises on the next cycle instead.
- R5: A `conv_req` while `nap_o` is high drops `nap_o` on the next cycle. `convst_n_o` then falls exactly `NAP_CYC` cycles after `nap_o` fell.
- R6: `stby_req` high while the block is ready or in the light state raises `stby_o` on the next cycle, with `nap_o` low. `stby_o` stays high for as long as `stby_req` stays high. A `stby_req` that arrives during a conversion takes effect only on the cycle after that conversion ends.
- R7: After `stby_req` falls, `stby_o` falls on the next cycle. `ready_o` rises exactly `INT_CYC` cycles later when `ext_ref_sel` = 0, or `EXT_CYC` cycles later when `ext_ref_sel` = 1.
- R8: `convst_n_o` never falls fewer cycles after `nap_o` or `stby_o` has fallen than the recovery time of the state that was left. This holds for every order of requests.
- R9: The first `conv_req` made during recovery is held. The conversion then starts on the cycle the recovery time expires, and `ready_o` stays low throughout.
- R10: `err_o` pulses high on the cycle after a `conv_req` that is rejected, and no conversion is started for that request. A request is rejected if it is a second request during the same recovery, or if it arrives in the deep state or during a conversion.
- R11: `stby_req` during recovery abandons both the recovery and any held request: `stby_o` rises on the next cycle, and no conversion is started for the held request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_MHZ |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | input | 1 | One-cycle conversion request |
| auto_nap_en | input | 1 | Enter the light state after every conversion |
| stby_req | input | 1 | Level request for the deep state |
| ext_ref_sel | input | 1 | 1 = external reference stays powered in the deep state |
| cnv_busy_n | input | 1 | Converter busy, low while converting |
| nap_o | output | 1 | Light power-down line to the converter |
| stby_o | output | 1 | Deep power-down line to the converter |
| convst_n_o | output | 1 | Active-low convert-start strobe |
| ready_o | output | 1 | A request now starts a conversion at once |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
A recovery counter that is loaded with the wrong value, or that expires early, shows up at the ports as a shortened interval between the fall of a power-down line and the next falling edge of `convst_n_o` or the next rise of `ready_o`. The deviation is visible on the very first conversion after wake-up. A lost or duplicated held request shows up within one recovery window, as a missing or extra strobe or as a missing `err_o` pulse. A state machine stuck on the wrong side of a conversion shows up one cycle after `cnv_busy_n` returns high, because `nap_o`, `stby_o` or `ready_o` does not take its expected value.

// File: rtl/adc_wake_pkg.sv
package adc_wake_pkg;

  typedef enum logic [2:0] {
    S_WAKE = 3'd0,
    S_IDLE = 3'd1,
    S_CONV = 3'd2,
    S_NAP  = 3'd3,
    S_STBY = 3'd4
  } wake_state_e;

  // ceiling of ns * mhz / 1000, never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(ns) * longint'(mhz);
    cyc  = (prod + 64'd999) / 64'd1000;
    if (cyc == 64'd0) cyc = 64'd1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int unsigned CW = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= RST_VAL;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  // the cycle that starts with one count left is the last recovery cycle
  assign expired = (cnt == CW'(1));

  p_no_expire_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val > CW'(1)) |=> !expired);

endmodule

// File: rtl/cnv_pulse.sv
module cnv_pulse #(
  parameter int unsigned WIDTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic convst_n,
  output logic active
);

  localparam int unsigned PW = $clog2(WIDTH + 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= PW'(WIDTH);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active   = (cnt != '0);
  assign convst_n = !active;

  generate
    if (WIDTH > 1) begin : g_wide
      p_pulse_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst_n) |=> !convst_n);
    end else begin : g_narrow
      p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(convst_n) && !fire) |=> convst_n);
    end
  endgenerate

endmodule

// File: rtl/adc_wake_seq.sv
module adc_wake_seq
  import adc_wake_pkg::*;
#(
  parameter int unsigned CLK_MHZ          = 100,
  parameter int unsigned NAP_WAKE_NS      = 100,
  parameter int unsigned STBY_INT_WAKE_NS = 200000,
  parameter int unsigned STBY_EXT_WAKE_NS = NAP_WAKE_NS,
  parameter int unsigned CNV_LOW_CYC      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_req,
  input  logic auto_nap_en,
  input  logic stby_req,
  input  logic ext_ref_sel,
  input  logic cnv_busy_n,
  output logic nap_o,
  output logic stby_o,
  output logic convst_n_o,
  output logic ready_o,
  output logic err_o
);

  localparam int unsigned NAP_CYC = ns_to_cycles(NAP_WAKE_NS, CLK_MHZ);
  localparam int unsigned INT_CYC = ns_to_cycles(STBY_INT_WAKE_NS, CLK_MHZ);
  localparam int unsigned EXT_CYC = ns_to_cycles(STBY_EXT_WAKE_NS, CLK_MHZ);
  localparam int unsigned MAX_A   = (NAP_CYC > EXT_CYC) ? NAP_CYC : EXT_CYC;
  localparam int unsigned MAX_CYC = (INT_CYC > MAX_A) ? INT_CYC : MAX_A;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  wake_state_e   state, state_nxt;
  logic          pend, pend_nxt;
  logic          seen_busy, seen_nxt;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;
  logic          cnv_fire, pulse_active, reject;

  wake_timer #(.CW(CW), .RST_VAL(CW'(INT_CYC))) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  cnv_pulse #(.WIDTH(CNV_LOW_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(cnv_fire),
    .convst_n(convst_n_o), .active(pulse_active)
  );

  always_comb begin
    state_nxt = state;
    pend_nxt  = pend;
    seen_nxt  = seen_busy;
    tmr_load  = 1'b0;
    tmr_val   = CW'(NAP_CYC);
    cnv_fire  = 1'b0;
    reject    = 1'b0;
    unique case (state)
      S_STBY: begin
        reject = conv_req;
        if (!stby_req) begin
          state_nxt = S_WAKE;
          tmr_load  = 1'b1;
          tmr_val   = ext_ref_sel ? CW'(EXT_CYC) : CW'(INT_CYC);
          pend_nxt  = 1'b0;
        end
      end
      S_NAP: begin
        if (stby_req) begin
          state_nxt = S_STBY;
          reject    = conv_req;
        end else if (conv_req) begin
          state_nxt = S_WAKE;
          tmr_load  = 1'b1;
          pend_nxt  = 1'b1;
        end
      end
      S_WAKE: begin
        if (stby_req) begin
          state_nxt = S_STBY;
          pend_nxt  = 1'b0;
          reject    = conv_req;
        end else if (tmr_expired) begin
          reject   = pend && conv_req;
          pend_nxt = 1'b0;
          if (pend || conv_req) begin
            cnv_fire  = 1'b1;
            seen_nxt  = 1'b0;
            state_nxt = S_CONV;
          end else begin
            state_nxt = S_IDLE;
          end
        end else if (conv_req) begin
          if (pend) reject   = 1'b1;
          else      pend_nxt = 1'b1;
        end
      end
      S_IDLE: begin
        if (stby_req) begin
          state_nxt = S_STBY;
          reject    = conv_req;
        end else if (conv_req) begin
          cnv_fire  = 1'b1;
          seen_nxt  = 1'b0;
          state_nxt = S_CONV;
        end
      end
      S_CONV: begin
        reject = conv_req;
        if (!cnv_busy_n) seen_nxt = 1'b1;
        if (seen_busy && cnv_busy_n && !pulse_active) begin
          seen_nxt = 1'b0;
          if (stby_req)         state_nxt = S_STBY;
          else if (auto_nap_en) state_nxt = S_NAP;
          else                  state_nxt = S_IDLE;
        end
      end
      default: state_nxt = S_WAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_WAKE;
      pend      <= 1'b0;
      seen_busy <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      state     <= state_nxt;
      pend      <= pend_nxt;
      seen_busy <= seen_nxt;
      err_o     <= reject;
    end
  end

  assign nap_o   = (state == S_NAP);
  assign stby_o  = (state == S_STBY);
  assign ready_o = (state == S_IDLE);

  p_power_lines_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(nap_o && stby_o));
  p_no_start_in_stby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stby_o |-> convst_n_o);
  p_quiet_during_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAKE) |-> convst_n_o);
  p_ready_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (convst_n_o && !nap_o && !stby_o));
  p_err_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(conv_req));

endmodule

// File: tb/adc_wake_seq_test.sv
`timescale 1ns/1ps
module adc_wake_seq_test;

  localparam int unsigned MHZ    = 250;
  localparam int unsigned NAP_NS = 101;
  localparam int unsigned INT_NS = 2000;
  localparam int unsigned EXT_NS = 333;
  localparam int unsigned W      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_req = 1'b0, auto_nap_en = 1'b0, stby_req = 1'b0, ext_ref_sel = 1'b0;
  logic cnv_busy_n;
  logic nap_o, stby_o, convst_n_o, ready_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_wake_seq #(
    .CLK_MHZ(MHZ), .NAP_WAKE_NS(NAP_NS), .STBY_INT_WAKE_NS(INT_NS),
    .STBY_EXT_WAKE_NS(EXT_NS), .CNV_LOW_CYC(W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .auto_nap_en(auto_nap_en),
    .stby_req(stby_req), .ext_ref_sel(ext_ref_sel), .cnv_busy_n(cnv_busy_n),
    .nap_o(nap_o), .stby_o(stby_o), .convst_n_o(convst_n_o),
    .ready_o(ready_o), .err_o(err_o)
  );

  // smallest whole cycle count covering ns at mhz, counted upward
  function automatic int cyc_for(int ns, int mhz);
    int c = 0;
    while (c * 1000 < ns * mhz) c++;
    if (c == 0) c = 1;
    return c;
  endfunction

  int nap_c, int_c, ext_c;

  // converter model: busy low for a while shortly after the strobe falls
  logic prev_cnv = 1'b1;
  int   bcnt = 0;
  always @(posedge clk) begin
    prev_cnv <= convst_n_o;
    if (prev_cnv && !convst_n_o) bcnt <= 1;
    else if (bcnt != 0)          bcnt <= (bcnt == 8) ? 0 : bcnt + 1;
  end
  assign cnv_busy_n = !(bcnt >= 2 && bcnt <= 7);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R8 monitor: recovery window since the last power-down exit
  int  since = 0, need = 0, cnv_count = 0;
  bit  armed = 0;
  logic m_nap = 0, m_stby = 0, m_cnv = 1;
  always @(negedge clk) begin
    if (!rst_n) begin
      since = 0; need = cyc_for(INT_NS, MHZ); armed = 1;
    end else begin
      if (m_nap && !nap_o) begin
        since = 0; need = cyc_for(NAP_NS, MHZ); armed = 1;
      end else if (m_stby && !stby_o) begin
        since = 0; need = ext_ref_sel ? cyc_for(EXT_NS, MHZ) : cyc_for(INT_NS, MHZ);
        armed = 1;
      end else begin
        since++;
      end
      if (m_cnv && !convst_n_o) begin
        cnv_count++;
        if (armed) begin
          chk(since >= need, "R8 early start", since, need);
          armed = 0;
        end
      end
    end
    m_nap = nap_o; m_stby = stby_o; m_cnv = convst_n_o;
  end

  task automatic send_req(output bit e);
    conv_req = 1'b1;
    @(negedge clk);
    e = err_o;
    conv_req = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (cnv_busy_n && g < 100) begin @(negedge clk); g++; end
    while (!cnv_busy_n && g < 200) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic count_to_ready(output int n);
    n = 0;
    while (!ready_o && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    bit e, e2, saw_ready;
    int n, c0, r;
    nap_c = cyc_for(NAP_NS, MHZ);
    int_c = cyc_for(INT_NS, MHZ);
    ext_c = cyc_for(EXT_NS, MHZ);
    r = $urandom(32'h1d5);
    repeat (3) @(negedge clk);
    chk(!nap_o && !stby_o && convst_n_o && !ready_o && !err_o, "R1 reset outputs",
        {nap_o, stby_o, convst_n_o, ready_o, err_o}, 5'b00100);
    rst_n = 1'b1;
    count_to_ready(n);
    chk(n == int_c, "R1 first ready", n, int_c);

    // R3 single conversion from ready, automatic nap off
    send_req(e);
    chk(e == 0 && !ready_o, "R3 accept", {e, ready_o}, 0);
    n = 0;
    while (!convst_n_o && n < 50) begin n++; @(negedge clk); end
    chk(n == W, "R3 strobe width", n, W);
    wait_done();
    chk(ready_o && !nap_o, "R4 ready after end", {ready_o, nap_o}, 2'b10);

    // R4 automatic nap
    auto_nap_en = 1'b1;
    send_req(e);
    wait_done();
    chk(nap_o && !ready_o, "R4 nap after end", {nap_o, ready_o}, 2'b10);

    // R5 / R2 / R9 request while napping
    send_req(e);
    chk(!nap_o && e == 0, "R5 nap released", {nap_o, e}, 0);
    n = 0; saw_ready = 0;
    while (convst_n_o && n < 5000) begin
      @(negedge clk); n++;
      if (ready_o) saw_ready = 1;
    end
    chk(n == nap_c, "R5 R2 nap recovery", n, nap_c);
    chk(!saw_ready, "R9 no ready while held", saw_ready, 0);
    wait_done();

    // R10 / R9 second request during recovery and request while converting
    c0 = cnv_count;
    send_req(e);
    n = 0;
    send_req(e2);
    n = 1;
    chk(e2 == 1, "R10 second request flagged", e2, 1);
    while (convst_n_o && n < 5000) begin @(negedge clk); n++; end
    chk(n == nap_c, "R9 held request issued on expiry", n, nap_c);
    while (cnv_busy_n) @(negedge clk);
    send_req(e);
    chk(e == 1, "R10 request during conversion", e, 1);
    wait_done();
    chk(cnv_count - c0 == 1, "R10 no extra strobe", cnv_count - c0, 1);

    // R6 / R7 deep state from nap, external reference
    stby_req = 1'b1;
    @(negedge clk);
    chk(stby_o && !nap_o, "R6 deep from nap", {stby_o, nap_o}, 2'b10);
    c0 = cnv_count;
    send_req(e);
    chk(e == 1, "R10 request in deep state", e, 1);
    ext_ref_sel = 1'b1;
    repeat (4) @(negedge clk);
    chk(cnv_count == c0 && stby_o, "R10 R6 no strobe in deep", cnv_count - c0, 0);
    stby_req = 1'b0;
    @(negedge clk);
    chk(!stby_o, "R7 deep released", stby_o, 0);
    count_to_ready(n);
    chk(n == ext_c, "R7 external reference recovery", n, ext_c);

    // R7 internal reference from ready
    ext_ref_sel = 1'b0;
    stby_req = 1'b1;
    @(negedge clk);
    chk(stby_o, "R6 deep from ready", stby_o, 1);
    repeat (5) @(negedge clk);
    stby_req = 1'b0;
    @(negedge clk);
    count_to_ready(n);
    chk(n == int_c, "R7 internal reference recovery", n, int_c);

    // R11 deep request abandons recovery and held request
    send_req(e);
    wait_done();
    send_req(e);
    c0 = cnv_count;
    repeat (3) @(negedge clk);
    stby_req = 1'b1;
    @(negedge clk);
    chk(stby_o, "R11 deep during recovery", stby_o, 1);
    stby_req = 1'b0;
    @(negedge clk);
    count_to_ready(n);
    chk(n == int_c, "R11 full recovery", n, int_c);
    chk(cnv_count == c0, "R11 held request dropped", cnv_count - c0, 0);

    // R6 deferred deep request during a conversion
    auto_nap_en = 1'b0;
    send_req(e);
    while (cnv_busy_n) @(negedge clk);
    stby_req = 1'b1;
    @(negedge clk);
    chk(!stby_o, "R6 deferred while converting", stby_o, 0);
    while (!cnv_busy_n) @(negedge clk);
    @(negedge clk);
    chk(stby_o, "R6 deep after conversion", stby_o, 1);
    stby_req = 1'b0;
    count_to_ready(n);

    // random mix, R8 watched by the monitor
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 4)
        0: send_req(e);
        1: begin
          if (stby_req) stby_req = 1'b0;
          else begin ext_ref_sel = 1'($urandom % 2); stby_req = 1'b1; end
          @(negedge clk);
        end
        2: begin auto_nap_en = 1'($urandom % 2); @(negedge clk); end
        default: repeat (($urandom % 80) + 1) @(negedge clk);
      endcase
      chk(!(ready_o && (nap_o || stby_o || !convst_n_o)), "R8 ready consistency",
          {nap_o, stby_o, convst_n_o}, 3'b001);
    end
    stby_req = 1'b0;
    repeat (600) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule